// File: doc/BRIEF.md
# Self-timed nonvolatile byte store controller

This block sits between a CPU's register interface and a small nonvolatile byte array. The array is modelled as a register file. The CPU loads an address register and a write-data register. It then issues commands by writing a three-bit control word. A read copies the addressed byte to the read-data output and holds the CPU stalled for a short, fixed time.

A write is guarded by an arming step. Software first sets the arm bit. It must then raise the write strobe within a short window of CPU cycles. A write that is accepted stalls the CPU for two cycles and then continues in the background. The background part runs for a fixed number of cycles of a separate timing clock. While it runs, a busy flag is set. When the write ends, a one-cycle ready pulse is raised, which can serve as an interrupt request. A write that has been accepted does not start its timer while an external flash self-programming busy input is high.

The timer runs in its own clock domain. The start and finish events cross between the domains as toggles through two-flop synchronizers.

Top module: `eeprom_ctl`

## Requirements
- R1: A read command (control bit 0 set, bit 1 clear) accepted while idle loads `rd_data` with the addressed byte and holds `stall` high for exactly four CPU cycles, starting in the cycle after the command.
- R2: An accepted write holds `stall` high for exactly two CPU cycles, starting in the cycle after the command. During those cycles and afterwards, `busy` stays high until the write completes.
- R3: Once the timer has been started, the background write lasts at least `TWRITE` timing-clock cycles. Only then is the byte stored in the array and `busy` cleared.
- R4: Setting control bit 2 arms writing. `wr_armed` then stays high for four CPU cycles and clears itself unless a write consumes it first.
- R5: A write strobe (control bit 1) takes effect only while `wr_armed` is high. A strobe without arming, or after the window has expired, starts nothing.
- R6: While `flash_busy` is high, a pending write does not start its timer. It starts after `flash_busy` falls.
- R7: While `busy` is high, read commands are ignored and `rd_data` keeps its value. Writes to the address and data registers are also ignored.
- R8: `ready` pulses high for exactly one CPU cycle, in the cycle in which `busy` falls, and is low at all other times.
- R9: After reset, `stall`, `busy`, `wr_armed` and `ready` are low and `rd_data` is zero. Array contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | CPU-domain active-low reset |
| tclk | input | 1 | Timing oscillator clock |
| trst_n | input | 1 | Timing-domain active-low reset |
| addr_we | input | 1 | Load address register |
| addr_in | input | AW | Address value |
| data_we | input | 1 | Load write-data register |
| data_in | input | DW | Write-data value |
| ctl_we | input | 1 | Control write strobe |
| ctl_in | input | 3 | Bit 0 read, bit 1 write strobe, bit 2 arm |
| flash_busy | input | 1 | Flash self-programming in progress |
| rd_data | output | DW | Last byte read |
| stall | output | 1 | CPU halt request |
| wr_armed | output | 1 | Write window open |
| busy | output | 1 | Background write in progress |
| ready | output | 1 | One-cycle write-complete pulse |

## Verification
The bench builds the block with `TWRITE` reduced to 20 and the timing clock at a 7 ns period. This lets many complete background writes, including one held back by `flash_busy`, fit in a short run. Shortening the count also makes the lower and upper bounds on the timed duration easy to measure. The default address and data widths are kept, so the arming window, the stall lengths and the freezing of registers during a write are exercised exactly as they are in the full configuration.

// File: rtl/eeprom_ctl.sv
module eeprom_ctl #(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int TWRITE = 26368
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclk,
  input  logic          trst_n,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_in,
  input  logic          data_we,
  input  logic [DW-1:0] data_in,
  input  logic          ctl_we,
  input  logic [2:0]    ctl_in,
  input  logic          flash_busy,
  output logic [DW-1:0] rd_data,
  output logic          stall,
  output logic          wr_armed,
  output logic          busy,
  output logic          ready
);
  localparam int DEPTH   = 1 << AW;
  localparam int TW      = $clog2(TWRITE + 1);
  localparam int RD_HOLD = 4;
  localparam int WR_HOLD = 2;
  localparam int WINDOW  = 4;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic [2:0]    stl, win;
  logic          pend, s_tgl, d_seen;
  logic [1:0]    d_sync;
  logic [1:0]    s_sync;
  logic          s_seen, run, d_tgl;
  logic [TW-1:0] tcnt;

  wire idle  = !busy && stl == 3'd0;
  wire rd_go = ctl_we && ctl_in[0] && !ctl_in[1] && idle;
  wire wr_go = ctl_we && ctl_in[1] && wr_armed && idle;
  wire arm   = ctl_we && ctl_in[2] && !ctl_in[1] && idle;
  wire done  = d_sync[1] ^ d_seen;

  assign stall = stl != 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdat_q   <= '0;
      rd_data  <= '0;
      stl      <= '0;
      win      <= '0;
      wr_armed <= 1'b0;
      busy     <= 1'b0;
      pend     <= 1'b0;
      s_tgl    <= 1'b0;
      d_sync   <= '0;
      d_seen   <= 1'b0;
      ready    <= 1'b0;
    end else begin
      d_sync <= {d_sync[0], d_tgl};
      d_seen <= d_sync[1];
      ready  <= done;
      if (addr_we && !busy) addr_q <= addr_in;
      if (data_we && !busy) wdat_q <= data_in;
      if (wr_go)               stl <= 3'(WR_HOLD);
      else if (rd_go)          stl <= 3'(RD_HOLD);
      else if (stl != 3'd0)    stl <= stl - 3'd1;
      if (rd_go) rd_data <= mem[addr_q];
      if (wr_go) begin
        wr_armed <= 1'b0;
      end else if (arm) begin
        wr_armed <= 1'b1;
        win      <= 3'(WINDOW);
      end else if (wr_armed) begin
        win <= win - 3'd1;
        if (win == 3'd1) wr_armed <= 1'b0;
      end
      if (wr_go) begin
        busy <= 1'b1;
        pend <= 1'b1;
      end else if (pend && !flash_busy) begin
        pend  <= 1'b0;
        s_tgl <= ~s_tgl;
      end
      if (done) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (done) mem[addr_q] <= wdat_q;
  end

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      s_sync <= '0;
      s_seen <= 1'b0;
      run    <= 1'b0;
      tcnt   <= '0;
      d_tgl  <= 1'b0;
    end else begin
      s_sync <= {s_sync[0], s_tgl};
      if (s_sync[1] != s_seen) begin
        s_seen <= s_sync[1];
        run    <= 1'b1;
        tcnt   <= TW'(TWRITE);
      end else if (run) begin
        tcnt <= tcnt - 1'b1;
        if (tcnt == TW'(1)) begin
          run   <= 1'b0;
          d_tgl <= ~d_tgl;
        end
      end
    end
  end

  // R1
  rd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> stall ##1 stall ##1 stall ##1 stall ##1 !stall);
  // R2
  wr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> stall && busy ##1 stall && busy ##1 !stall);
  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R4
  arm_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_armed) |-> ##4 !wr_armed);
  // R6
  flash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && flash_busy) |=> $stable(s_tgl));
  // R7
  rd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rd_data));
  // R7
  addr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q) && $stable(wdat_q));
  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !busy && $past(busy));
endmodule

// File: tb/test_eeprom_ctl.sv
module test_eeprom_ctl;
  localparam int AW = 4, DW = 8, TWRITE = 20;
  logic clk = 0, tclk = 0, rst_n = 0, trst_n = 0;
  logic addr_we = 0, data_we = 0, ctl_we = 0, flash_busy = 0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic [2:0] ctl_in = '0;
  logic [DW-1:0] rd_data;
  logic stall, wr_armed, busy, ready;

  eeprom_ctl #(.AW(AW), .DW(DW), .TWRITE(TWRITE)) i_eeprom_ctl (
    .clk(clk), .rst_n(rst_n), .tclk(tclk), .trst_n(trst_n),
    .addr_we(addr_we), .addr_in(addr_in), .data_we(data_we), .data_in(data_in),
    .ctl_we(ctl_we), .ctl_in(ctl_in), .flash_busy(flash_busy),
    .rd_data(rd_data), .stall(stall), .wr_armed(wr_armed), .busy(busy), .ready(ready));

  always #2 clk = ~clk;
  always #3.5 tclk = ~tclk;

  int tests = 0, fails = 0;
  int m_stl = 0, m_win = 0, tcount = 0;
  bit m_armed = 0, m_busy = 0;
  int m_addr = 0, m_data = 0, m_rd = 0, w_addr = 0, w_data = 0;
  int mem [int];

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge tclk)
    if (!m_busy) tcount <= 0;
    else if (!flash_busy) tcount <= tcount + 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_stl = 0; m_win = 0; m_armed = 0; m_busy = 0; m_addr = 0; m_data = 0; m_rd = 0;
      if ($time > 20) begin
        chk("R9 stall", stall, 0); chk("R9 busy", busy, 0);
        chk("R9 wr_armed", wr_armed, 0); chk("R9 ready", ready, 0); chk("R9 rd_data", rd_data, 0);
      end
    end else begin
      bit idle, rd_go, wr_go, arm, fell;
      idle  = !m_busy && m_stl == 0;
      rd_go = ctl_we && ctl_in[0] && !ctl_in[1] && idle;
      wr_go = ctl_we && ctl_in[1] && m_armed && idle;
      arm   = ctl_we && ctl_in[2] && !ctl_in[1] && idle;
      fell  = m_busy && !busy;
      if (fell) begin
        chk("R3 timed length min", int'(tcount >= TWRITE), 1);
        chk("R3 timed length max", int'(tcount <= TWRITE + 6), 1);
        mem[w_addr] = w_data;
        m_busy = 0;
      end
      chk("R8 ready", ready, int'(fell));
      if (rd_go) m_rd = mem.exists(m_addr) ? mem[m_addr] : 0;
      if (addr_we && !(m_busy || fell)) m_addr = addr_in;
      if (data_we && !(m_busy || fell)) m_data = data_in;
      if (wr_go) m_stl = 2; else if (rd_go) m_stl = 4; else if (m_stl > 0) m_stl--;
      if (wr_go) m_armed = 0;
      else if (arm) begin m_armed = 1; m_win = 4; end
      else if (m_armed) begin if (m_win == 1) m_armed = 0; m_win--; end
      if (wr_go) begin m_busy = 1; w_addr = m_addr; w_data = m_data; end
      chk("R1/R2 stall", stall, int'(m_stl != 0));
      chk("R4/R5 wr_armed", wr_armed, int'(m_armed));
      chk("R1/R7 rd_data", rd_data, m_rd);
      chk("R2/R5/R6 busy", busy, int'(m_busy));
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); #1; endtask
  task automatic ctl(logic [2:0] v);
    ctl_we = 1; ctl_in = v; cyc(1); ctl_we = 0; ctl_in = 0;
  endtask
  task automatic set_ad(int a, int d);
    addr_we = 1; addr_in = AW'(a); data_we = 1; data_in = DW'(d); cyc(1);
    addr_we = 0; data_we = 0;
  endtask
  task automatic wait_idle();
    int g = 0;
    while ((busy || stall) && g < 2000) begin cyc(1); g++; end
    cyc(1);
  endtask
  task automatic write_byte(int a, int d, int gap);
    set_ad(a, d); ctl(3'b100); if (gap > 0) cyc(gap); ctl(3'b010); wait_idle();
  endtask

  initial begin
    cyc(6); rst_n = 1; trst_n = 1; cyc(2);
    write_byte(3, 8'hA5, 0);
    write_byte(7, 8'h3C, 3);
    set_ad(3, 0); ctl(3'b001); cyc(6);
    chk("R1 readback", rd_data, 8'hA5);
    // R5: strobe without arming
    set_ad(9, 8'h11); ctl(3'b010); cyc(3);
    chk("R5 no arm no busy", busy, 0);
    // R5: strobe after window expired
    ctl(3'b100); cyc(5); ctl(3'b010); cyc(3);
    chk("R5 late strobe ignored", busy, 0);
    // R7: address/data writes and read during busy
    set_ad(5, 8'h77); ctl(3'b100); ctl(3'b010); cyc(3);
    set_ad(6, 8'h99); ctl(3'b001); cyc(2);
    chk("R7 rd_data held", rd_data, 8'hA5);
    wait_idle();
    ctl(3'b001); cyc(6);
    chk("R7 addr frozen readback", rd_data, 8'h77);
    // R6: flash busy delays start
    flash_busy = 1;
    set_ad(12, 8'hC3); ctl(3'b100); ctl(3'b010); cyc(60);
    chk("R6 held busy", busy, 1);
    flash_busy = 0; wait_idle();
    set_ad(12, 0); ctl(3'b001); cyc(6);
    chk("R6 written after release", rd_data, 8'hC3);
    set_ad(7, 0); ctl(3'b001); cyc(6);
    chk("R1 second readback", rd_data, 8'h3C);
    // R9: reset clears state
    rst_n = 0; trst_n = 0; cyc(3); rst_n = 1; trst_n = 1; cyc(2);
    set_ad(3, 0); ctl(3'b001); cyc(6);
    chk("R9 array kept", rd_data, 8'hA5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule